// File: doc/BRIEF.md
# Priority-Assignable Interrupt Controller

This block collects interrupt requests from five fixed system sources and from a group of peripheral request lines. It presents one vector at a time to the processor. Each peripheral line is routed to one of twelve user slots by a per-peripheral slot field, so software decides which peripheral outranks which. The five fixed sources sit above all user slots. The resulting seventeen priority levels are numbered 0 to 16, and a lower number wins.

Requests are captured into pending latches and can be hidden by a per-level mask. The winning level is offered on a valid/ready vector stream. The processor accepts a vector by raising `irq_ready` while `irq_valid` is high. Acceptance clears the pending bit and moves that level into service. The processor signals the end of a handler with `irq_ret`.

Two service modes are available. In nesting mode, a level is offered only if it outranks the level currently in service. In non-nesting mode, nothing but the reset level is offered until the handler returns. Back-pressure rule: while `irq_ready` is low, the offer is held and no state changes. The offered vector may still be replaced by a higher-ranking arrival before it is taken. The offer is withdrawn only when a mask or a mode rule hides it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Peripheral line p requests level 5+s, where s = `per_slot[4p+3:4p]`. Slot values 12 to 15 leave the line unconnected. Several lines that name the same slot share that level.
- R2: System request bit i requests level i: bit 0 reset, bit 1 emulator, bit 2 power-down, bit 3 emulator kernel, bit 4 stack. The lowest-numbered eligible level is the one offered.
- R3: A request held for one clock stays pending until its vector is accepted. If a request for a level arrives in the same cycle that level is accepted, the level stays pending.
- R4: Setting `lvl_mask` bit L to 1 keeps level L from being offered, and its pending state is kept. Bit 0 has no effect, so reset cannot be masked.
- R5: `irq_valid` and `irq_vec` depend only on registered state and on the present mask and mode. A cycle with valid and ready both high clears that pending bit and puts the level into service at the same edge. The offer holds while ready is low.
- R6: In non-nesting mode (`nest_en`=0), while a level is in service, only level 0 may be offered, and only if level 0 is not itself in service.
- R7: In nesting mode (`nest_en`=1), while a level is in service, a pending level is offered only if its number is below the number of the level in service.
- R8: `irq_ret` ends service of the most recent level, and `svc_lvl` then shows the level it interrupted. `irq_ret` with nothing in service is ignored. `irq_ret` together with an accept ends the old level and enters the new one.
- R9: After reset, nothing is pending or in service: `irq_valid`=0 and `svc_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_req | input | 5 | Fixed system requests (bit i is level i) |
| per_req | input | NPER (8) | Peripheral request lines |
| per_slot | input | NPER*4 (32) | Slot field per peripheral, 4 bits each |
| lvl_mask | input | 17 | Per-level mask, 1 hides the level, bit 0 ignored |
| nest_en | input | 1 | 1 selects nesting mode, 0 non-nesting |
| irq_valid | output | 1 | A vector is offered |
| irq_ready | input | 1 | Processor accepts the offered vector |
| irq_vec | output | 5 | Offered level number |
| irq_ret | input | 1 | Return from the current handler |
| svc_busy | output | 1 | At least one level is in service |
| svc_lvl | output | 5 | Most recent level in service (0 when idle) |

## Verification
A request driven for one cycle is latched at the next rising edge. The vector it produces is visible right after that edge, because the offer is computed combinationally from the latches. An accept or a return changes `svc_busy`, `svc_lvl` and the offer at the edge where it is sampled. The bench drives all inputs just after a rising edge and reads the outputs one time unit later, so each result is read in the cycle it is due. Mask changes are combinational, and their effect is read without any clock edge in between.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSYS = 5;
  localparam int LVL_RESET = 0;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
  parameter int NPER  = 8,
  parameter int NSLOT = 12,
  parameter int SW    = 4
) (
  input  logic [NPER-1:0]    per_req,
  input  logic [NPER*SW-1:0] per_slot,
  output logic [NSLOT-1:0]   slot_req
);
  for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
    logic [NPER-1:0] hit;
    for (genvar gp = 0; gp < NPER; gp++) begin : g_per
      assign hit[gp] = (per_slot[gp*SW +: SW] == SW'(gs));
    end
    assign slot_req[gs] = |(hit & per_req);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NLEV = 17,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLEV-1:0] pend,
  input  logic [NLEV-1:0] mask,
  input  logic            nest_en,
  input  logic            busy,
  input  logic [LW-1:0]   top_lvl,
  output logic            valid,
  output logic [LW-1:0]   vec
);
  logic [NLEV-1:0] elig;
  logic            any;
  logic            allow;

  assign elig = pend & ~{mask[NLEV-1:1], 1'b0};

  always_comb begin
    vec = '0;
    any = 1'b0;
    for (int i = NLEV-1; i >= 0; i--) begin
      if (elig[i]) begin
        vec = LW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (!busy)              allow = 1'b1;
    else if (top_lvl == '0) allow = 1'b0;
    else if (nest_en)       allow = (vec < top_lvl);
    else                    allow = (vec == '0);
  end

  assign valid = any & allow;

  a_r4_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
    valid && vec != '0 |-> !mask[vec]);
endmodule

// File: rtl/irq_svc_set.sv
module irq_svc_set #(
  parameter int NLEV = 17,
  parameter int LW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic          busy,
  output logic [LW-1:0] top_lvl
);
  // Entries are always pushed above the current top, so the lowest set
  // bit of the set is the top of the service stack.
  logic [NLEV-1:0] isv_q, isv_d, after_pop;

  assign after_pop = pop ? (isv_q & (isv_q - NLEV'(1))) : isv_q;
  assign isv_d = after_pop | (push ? (NLEV'(1) << push_lvl) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv_q <= '0;
    else        isv_q <= isv_d;
  end

  assign busy = |isv_q;

  always_comb begin
    top_lvl = '0;
    for (int i = NLEV-1; i >= 0; i--) begin
      if (isv_q[i]) top_lvl = LW'(i);
    end
  end

  a_r8_ret_pops: assert property (@(posedge clk) disable iff (!rst_n)
    pop && busy && !push |=> $countones(isv_q) == $countones($past(isv_q)) - 1);
  a_r7_push_above: assert property (@(posedge clk) disable iff (!rst_n)
    push && busy && !pop |-> push_lvl < top_lvl);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NPER  = 8,
  parameter int NSLOT = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [irq_pkg::NSYS-1:0] sys_req,
  input  logic [NPER-1:0]          per_req,
  input  logic [NPER*4-1:0]        per_slot,
  input  logic [16:0]              lvl_mask,
  input  logic                     nest_en,
  output logic                     irq_valid,
  input  logic                     irq_ready,
  output logic [4:0]               irq_vec,
  input  logic                     irq_ret,
  output logic                     svc_busy,
  output logic [4:0]               svc_lvl
);
  localparam int NLEV = irq_pkg::NSYS + NSLOT;
  localparam int LW   = $clog2(NLEV);
  localparam int SW   = $clog2(NSLOT);

  logic [NSLOT-1:0] slot_req;
  logic [NLEV-1:0]  raw, pend_q, pend_d, clr;
  logic             accept;

  irq_slot_map #(.NPER(NPER), .NSLOT(NSLOT), .SW(SW)) u_map (
    .per_req(per_req), .per_slot(per_slot), .slot_req(slot_req));

  assign raw    = {slot_req, sys_req};
  assign accept = irq_valid & irq_ready;
  assign clr    = accept ? (NLEV'(1) << irq_vec) : '0;
  assign pend_d = (pend_q & ~clr) | raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  irq_pick #(.NLEV(NLEV), .LW(LW)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(lvl_mask),
    .nest_en(nest_en), .busy(svc_busy), .top_lvl(svc_lvl),
    .valid(irq_valid), .vec(irq_vec));

  irq_svc_set #(.NLEV(NLEV), .LW(LW)) u_svc (
    .clk(clk), .rst_n(rst_n), .push(accept), .push_lvl(irq_vec),
    .pop(irq_ret), .busy(svc_busy), .top_lvl(svc_lvl));

  a_r3_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr));
  a_r5_accept_enters: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> svc_busy && svc_lvl == $past(irq_vec));
  a_r6_nonnest_reset_only: assert property (@(posedge clk) disable iff (!rst_n)
    !nest_en && svc_busy && irq_valid |-> irq_vec == '0);
  a_r7_only_higher: assert property (@(posedge clk) disable iff (!rst_n)
    svc_busy && irq_valid |-> irq_vec < svc_lvl);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // sys(5) per(8) mask(17) exp_valid(1) exp_vec(5)
  localparam logic [35:0] VEC [NV] = '{
    {5'h00, 8'h00, 17'h00000, 1'b0, 5'd0},
    {5'h00, 8'h01, 17'h00000, 1'b1, 5'd8},
    {5'h00, 8'h06, 17'h00000, 1'b1, 5'd5},
    {5'h00, 8'h10, 17'h00000, 1'b0, 5'd0},
    {5'h00, 8'h80, 17'h00000, 1'b0, 5'd0},
    {5'h00, 8'h04, 17'h00000, 1'b1, 5'd16},
    {5'h10, 8'h02, 17'h00000, 1'b1, 5'd4},
    {5'h10, 8'h02, 17'h00010, 1'b1, 5'd5},
    {5'h01, 8'h00, 17'h1FFFF, 1'b1, 5'd0},
    {5'h06, 8'h00, 17'h00000, 1'b1, 5'd1},
    {5'h00, 8'h09, 17'h00100, 1'b0, 5'd0},
    {5'h00, 8'h60, 17'h00000, 1'b1, 5'd6}
  };

  logic clk = 0, rst_n = 0;
  logic [4:0] sys_req = '0;
  logic [7:0] per_req = '0;
  logic [31:0] per_slot = 32'hC17F_3B03;
  logic [16:0] lvl_mask = '0;
  logic nest_en = 0, irq_ready = 0, irq_ret = 0;
  logic irq_valid, svc_busy;
  logic [4:0] irq_vec, svc_lvl;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .sys_req(sys_req), .per_req(per_req),
    .per_slot(per_slot), .lvl_mask(lvl_mask), .nest_en(nest_en),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vec(irq_vec),
    .irq_ret(irq_ret), .svc_busy(svc_busy), .svc_lvl(svc_lvl));

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; sys_req = '0; per_req = '0; irq_ready = 0; irq_ret = 0;
    tick; tick; rst_n = 1; tick;
  endtask

  task automatic pulse(input logic [4:0] s, input logic [7:0] p);
    sys_req = s; per_req = p; tick; sys_req = '0; per_req = '0; #1;
  endtask

  task automatic take; irq_ready = 1; tick; irq_ready = 0; #1; endtask
  task automatic ret;  irq_ret = 1;   tick; irq_ret = 0;   #1; endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset;
    chk("R9 valid after reset", irq_valid, 0);
    chk("R9 busy after reset", svc_busy, 0);

    // R1 R2 R4 table
    for (int i = 0; i < NV; i++) begin
      do_reset;
      lvl_mask = VEC[i][22:6];
      pulse(VEC[i][35:31], VEC[i][30:23]);
      chk($sformatf("R1/R2 vector %0d valid", i), irq_valid, VEC[i][5]);
      if (VEC[i][5]) chk($sformatf("R1/R2 vector %0d vec", i), irq_vec, VEC[i][4:0]);
    end
    lvl_mask = '0;

    do_reset;
    pulse(5'h00, 8'h20);                       // p5 -> level 12
    chk("R3 latched valid", irq_valid, 1);
    chk("R3 latched vec", irq_vec, 12);
    tick; tick; tick;
    chk("R5 held without ready", irq_valid, 1);
    chk("R5 held vec", irq_vec, 12);
    take;
    chk("R5 accept clears offer", irq_valid, 0);
    chk("R5 in service", svc_busy, 1);
    chk("R5 service level", svc_lvl, 12);

    pulse(5'h00, 8'h02);                       // level 5, non-nesting
    chk("R6 blocked while busy", irq_valid, 0);
    ret;
    chk("R8 idle after return", svc_busy, 0);
    chk("R3 kept through block", irq_vec, 5);
    chk("R3 kept valid", irq_valid, 1);

    nest_en = 1; #1;
    take;
    chk("R7 service 5", svc_lvl, 5);
    pulse(5'h00, 8'h04);                       // level 16
    chk("R7 lower not offered", irq_valid, 0);
    pulse(5'h10, 8'h00);                       // stack, level 4
    chk("R7 higher offered", irq_valid, 1);
    chk("R7 higher vec", irq_vec, 4);
    take;
    chk("R7 nested level", svc_lvl, 4);
    ret;
    chk("R8 back to outer", svc_lvl, 5);
    chk("R8 still busy", svc_busy, 1);
    chk("R7 16 still blocked", irq_valid, 0);
    ret;
    chk("R8 idle", svc_busy, 0);
    chk("R7 16 now offered", irq_vec, 16);
    take;

    nest_en = 0; #1;
    pulse(5'h01, 8'h00);
    chk("R6 reset preempts", irq_valid, 1);
    chk("R6 reset vec", irq_vec, 0);
    take;
    chk("R6 reset in service", svc_lvl, 0);
    ret;
    chk("R8 back to 16", svc_lvl, 16);
    ret;
    chk("R8 idle again", svc_busy, 0);
    ret;
    chk("R8 return when idle", svc_busy, 0);
    chk("R8 return when idle offer", irq_valid, 0);

    lvl_mask = 17'h00100;
    pulse(5'h00, 8'h01);                       // level 8 masked
    chk("R4 masked hidden", irq_valid, 0);
    lvl_mask = '0; #1;
    chk("R4 unmask shows", irq_valid, 1);
    chk("R4 unmask vec", irq_vec, 8);

    per_req = 8'h01; irq_ready = 1; tick; irq_ready = 0; per_req = '0; #1;
    chk("R3 set wins busy", svc_lvl, 8);
    ret;
    chk("R3 re-latched", irq_valid, 1);
    chk("R3 re-latched vec", irq_vec, 8);
    take;

    nest_en = 1; #1;
    pulse(5'h00, 8'h02);                       // level 5 over 8
    chk("R7 offer 5 over 8", irq_vec, 5);
    irq_ready = 1; irq_ret = 1; tick; irq_ready = 0; irq_ret = 0; #1;
    chk("R8 swap level", svc_lvl, 5);
    ret;
    chk("R8 swap left one", svc_busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule